// File: doc/BRIEF.md
# Cascaded Interrupt Status Controller

This block gathers up to 96 single-cycle event pulses into three 32-bit pending banks. It drives a set of masked interrupt levels from them. An event is named by a 7-bit code: the upper two bits pick a bank and the lower five pick a bit within that bank. Software acknowledges pending bits by writing ones to a bank. A separate clear-event port removes single bits, and it is the only way to empty the middle bank.

Bank 0 is the root bank. Its two top bits are summary flags, one for each of the other banks. Each flag is high whenever its bank holds any pending bit. Neither software writes nor the clear-event port can set or clear a flag directly. Each output level has one mask word per bank. The level is raised while any pending bit lines up with a set bit in its masks.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A set pulse with event code bits [6:5] = bank 0..2 and bits [4:0] = index sets that pending bit on the next clock edge; `pending_o` packs bank b into bits [32*b+31 : 32*b].
- R2: A set or clear pulse whose bank field is 3 changes no pending bit.
- R3: Root bit 30 equals the OR of bank 1 and root bit 31 equals the OR of bank 2; both update on the same edge as the bank they summarize.
- R4: A software write to bank 0 clears each of bits 29..0 written as one and leaves root bits 31 and 30 unchanged.
- R5: A software write to bank 2 clears every bit written as one; when bank 2 becomes empty, root bit 31 drops on that same edge.
- R6: Software writes to bank 1 have no effect; the clear-event port clears a bank 1 bit, and clearing the last one drops root bit 30.
- R7: When a set and a clear (from either source) hit the same bit on the same edge, the bit ends up set.
- R8: Output level L is high while, for some bank b, pending bank b ANDed with mask word (L, b) is nonzero. A mask write with a level number or bank number out of range changes nothing.
- R9: After reset all pending bits and all mask words are zero and every output level is low.
- R10: Set or clear pulses that address root bits 31 or 30 have no effect on those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_valid | input | 1 | Event set strobe |
| evt_set_num | input | 7 | Event code to set |
| evt_clr_valid | input | 1 | Event clear strobe |
| evt_clr_num | input | 7 | Event code to clear |
| sw_wr_en | input | 1 | Software write-one-to-clear strobe |
| sw_wr_bank | input | 2 | Bank addressed by the software write |
| sw_wr_data | input | 32 | Bits to clear |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_level | input | LVL_W (2) | Output level of the mask word |
| mask_wr_bank | input | 2 | Bank of the mask word |
| mask_wr_data | input | 32 | New mask word |
| pending_o | output | 96 | All three pending banks, bank 0 in the low word |
| irq_o | output | NUM_LEVELS (3) | Masked interrupt levels |

## Verification
The bench builds the block with its default three levels. With three levels the 2-bit level field has one unused code, so out-of-range mask writes can be tried. The 7-bit event code also covers the unused bank field 3. Every edge case is reachable: out-of-range event codes, the protected summary bits, and both banks emptying. The bench also checks collisions between sets and clears at the same bit.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int BANK_W = 32;
  localparam int BANKS  = 3;
  localparam int IDX_W  = $clog2(BANK_W);
  localparam int EVT_W  = 2 + IDX_W;

  typedef logic [BANK_W-1:0] bank_t;

  // summary flags live at the two top bits of the root bank
  localparam bank_t ROOT_PROT = {2'b11, {(BANK_W-2){1'b0}}};

  // next value of a bank: clears first, sets override
  function automatic bank_t bank_update(bank_t cur, bank_t clr, bank_t set);
    return (cur & ~clr) | set;
  endfunction

  // true when a masked bank has anything left
  function automatic logic masked_any(bank_t pend, bank_t mask);
    return |(pend & mask);
  endfunction
endpackage

// File: rtl/irq_evt_decode.sv
module irq_evt_decode
  import irq_cascade_pkg::*;
(
  input  logic                               valid,
  input  logic [EVT_W-1:0]                   num,
  output logic [BANKS-1:0][BANK_W-1:0]       hit
);
  logic [1:0]       bank_sel;
  logic [IDX_W-1:0] bit_sel;

  assign bank_sel = num[EVT_W-1 -: 2];
  assign bit_sel  = num[IDX_W-1:0];

  always_comb begin
    hit = '0;
    if (valid && int'(bank_sel) < BANKS)
      hit[bank_sel][bit_sel] = 1'b1;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_cascade_pkg::*;
#(
  parameter bit ROOT   = 1'b0,
  parameter bit SW_CLR = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  bank_t set_bits,
  input  bank_t clr_bits,
  input  logic  sw_en,
  input  bank_t sw_data,
  input  logic [1:0] casc,
  output bank_t q,
  output bank_t nxt
);
  localparam bank_t PROT = ROOT ? ROOT_PROT : '0;

  bank_t clr_all;
  bank_t base;

  always_comb begin
    clr_all = clr_bits | ((SW_CLR && sw_en) ? sw_data : '0);
    base    = bank_update(q, clr_all & ~PROT, set_bits & ~PROT);
    nxt     = (base & ~PROT) | ({casc, {(BANK_W-2){1'b0}}} & PROT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_cascade_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_bank,
  input  bank_t                        wr_data,
  input  logic [BANKS-1:0][BANK_W-1:0] pend,
  output logic                         irq
);
  logic [BANKS-1:0][BANK_W-1:0] mask_q;
  logic [BANKS-1:0]             bank_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '0;
    else if (wr_en && int'(wr_bank) < BANKS)
      mask_q[wr_bank] <= wr_data;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_hit[b] = masked_any(pend[b], mask_q[b]);
  end

  assign irq = |bank_hit;
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter  int NUM_LEVELS = 3,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_set_valid,
  input  logic [EVT_W-1:0]        evt_set_num,
  input  logic                    evt_clr_valid,
  input  logic [EVT_W-1:0]        evt_clr_num,
  input  logic                    sw_wr_en,
  input  logic [1:0]              sw_wr_bank,
  input  logic [BANK_W-1:0]       sw_wr_data,
  input  logic                    mask_wr_en,
  input  logic [LVL_W-1:0]        mask_wr_level,
  input  logic [1:0]              mask_wr_bank,
  input  logic [BANK_W-1:0]       mask_wr_data,
  output logic [BANKS*BANK_W-1:0] pending_o,
  output logic [NUM_LEVELS-1:0]   irq_o
);
  // named internal events, visible to the bound checker
  logic [BANKS-1:0][BANK_W-1:0] set_hit;
  logic [BANKS-1:0][BANK_W-1:0] clr_hit;
  logic [BANKS-1:0][BANK_W-1:0] pend_all;
  bank_t b0_q, b1_q, b2_q;
  bank_t b0_nxt, b1_nxt, b2_nxt;
  logic  casc_b1, casc_b2;
  logic  sw_b0, sw_b1, sw_b2;

  irq_evt_decode u_set_dec (.valid(evt_set_valid), .num(evt_set_num), .hit(set_hit));
  irq_evt_decode u_clr_dec (.valid(evt_clr_valid), .num(evt_clr_num), .hit(clr_hit));

  assign sw_b0 = sw_wr_en && (sw_wr_bank == 2'd0);
  assign sw_b1 = sw_wr_en && (sw_wr_bank == 2'd1);
  assign sw_b2 = sw_wr_en && (sw_wr_bank == 2'd2);

  assign casc_b1 = |b1_nxt;
  assign casc_b2 = |b2_nxt;

  irq_pend_bank #(.ROOT(1'b1), .SW_CLR(1'b1)) u_bank0 (
    .clk(clk), .rst_n(rst_n), .set_bits(set_hit[0]), .clr_bits(clr_hit[0]),
    .sw_en(sw_b0), .sw_data(sw_wr_data), .casc({casc_b2, casc_b1}),
    .q(b0_q), .nxt(b0_nxt));

  irq_pend_bank #(.ROOT(1'b0), .SW_CLR(1'b0)) u_bank1 (
    .clk(clk), .rst_n(rst_n), .set_bits(set_hit[1]), .clr_bits(clr_hit[1]),
    .sw_en(sw_b1), .sw_data(sw_wr_data), .casc(2'b00),
    .q(b1_q), .nxt(b1_nxt));

  irq_pend_bank #(.ROOT(1'b0), .SW_CLR(1'b1)) u_bank2 (
    .clk(clk), .rst_n(rst_n), .set_bits(set_hit[2]), .clr_bits(clr_hit[2]),
    .sw_en(sw_b2), .sw_data(sw_wr_data), .casc(2'b00),
    .q(b2_q), .nxt(b2_nxt));

  assign pend_all  = {b2_q, b1_q, b0_q};
  assign pending_o = pend_all;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    logic lvl_wr;
    assign lvl_wr = mask_wr_en && (int'(mask_wr_level) == l);
    irq_level_gate u_gate (
      .clk(clk), .rst_n(rst_n), .wr_en(lvl_wr), .wr_bank(mask_wr_bank),
      .wr_data(mask_wr_data), .pend(pend_all), .irq(irq_o[l]));
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    evt_set_valid,
  input logic                    evt_clr_valid,
  input logic [BANKS*BANK_W-1:0] set_hit,
  input logic                    sw_wr_en,
  input logic [1:0]              sw_wr_bank,
  input logic [BANK_W-1:0]       sw_wr_data,
  input logic [BANKS*BANK_W-1:0] pending_o
);
  localparam logic [BANKS*BANK_W-1:0] PROT_FLAT =
    {{((BANKS-1)*BANK_W){1'b0}}, ROOT_PROT};

  logic [BANKS*BANK_W-1:0] set_eff;
  assign set_eff = set_hit & ~PROT_FLAT;

  // R3: lower summary flag follows bank 1
  a_r3_flag_bank1: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o[BANK_W-2] == (|pending_o[2*BANK_W-1:BANK_W]));

  // R5: upper summary flag follows bank 2
  a_r5_flag_bank2: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o[BANK_W-1] == (|pending_o[3*BANK_W-1:2*BANK_W]));

  // R1 / R7: every accepted set lands, even against a clear
  a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set_valid |=> ((pending_o & $past(set_eff)) == $past(set_eff)));

  // R6: software writes never drop a bank 1 bit
  a_r6_bank1_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && sw_wr_bank == 2'd1 && !evt_clr_valid) |=>
      (($past(pending_o[2*BANK_W-1:BANK_W]) & ~pending_o[2*BANK_W-1:BANK_W]) == '0));

  // R4: root write-one-to-clear on the low bits
  a_r4_root_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && sw_wr_bank == 2'd0 && !evt_set_valid) |=>
      ((pending_o[BANK_W-3:0] & $past(sw_wr_data[BANK_W-3:0])) == '0));
endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set_valid(evt_set_valid),
  .evt_clr_valid(evt_clr_valid), .set_hit(set_hit), .sw_wr_en(sw_wr_en),
  .sw_wr_bank(sw_wr_bank), .sw_wr_data(sw_wr_data), .pending_o(pending_o));

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       evt_set_valid = 0, evt_clr_valid = 0, sw_wr_en = 0, mask_wr_en = 0;
  logic [6:0] evt_set_num = 0, evt_clr_num = 0;
  logic [1:0] sw_wr_bank = 0, mask_wr_level = 0, mask_wr_bank = 0;
  logic [31:0] sw_wr_data = 0, mask_wr_data = 0;
  logic [95:0] pending_o;
  logic [2:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_p [3];
  logic [31:0] m_mask [3][3];

  always #2 clk = ~clk;

  irq_cascade_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_set_valid(evt_set_valid), .evt_set_num(evt_set_num),
    .evt_clr_valid(evt_clr_valid), .evt_clr_num(evt_clr_num), .sw_wr_en(sw_wr_en),
    .sw_wr_bank(sw_wr_bank), .sw_wr_data(sw_wr_data), .mask_wr_en(mask_wr_en),
    .mask_wr_level(mask_wr_level), .mask_wr_bank(mask_wr_bank),
    .mask_wr_data(mask_wr_data), .pending_o(pending_o), .irq_o(irq_o));

  function automatic logic [2:0] ref_irq();
    logic [2:0] r = '0;
    for (int l = 0; l < 3; l++)
      for (int b = 0; b < 3; b++)
        if ((m_p[b] & m_mask[l][b]) != 0) r[l] = 1'b1;
    return r;
  endfunction

  // event code -> bank/bit, refusing bank 3 and the two root flags
  function automatic bit code_ok(logic [6:0] c);
    int b = c[6:5];
    int i = c[4:0];
    return (b < 3) && !(b == 0 && i >= 30);
  endfunction

  task automatic model_edge();
    logic [31:0] sv [3];
    logic [31:0] cv [3];
    for (int b = 0; b < 3; b++) begin sv[b] = 0; cv[b] = 0; end
    if (evt_set_valid && code_ok(evt_set_num)) sv[evt_set_num[6:5]][evt_set_num[4:0]] = 1'b1;
    if (evt_clr_valid && code_ok(evt_clr_num)) cv[evt_clr_num[6:5]][evt_clr_num[4:0]] = 1'b1;
    if (sw_wr_en && sw_wr_bank == 0) cv[0] = cv[0] | (sw_wr_data & 32'h3FFF_FFFF);
    if (sw_wr_en && sw_wr_bank == 2) cv[2] = cv[2] | sw_wr_data;
    for (int b = 0; b < 3; b++) m_p[b] = (m_p[b] & ~cv[b]) | sv[b];
    m_p[0][30] = (m_p[1] != 0);
    m_p[0][31] = (m_p[2] != 0);
    if (mask_wr_en && mask_wr_level < 3 && mask_wr_bank < 3)
      m_mask[mask_wr_level][mask_wr_bank] = mask_wr_data;
  endtask

  task automatic compare(string tag);
    logic [95:0] ep = {m_p[2], m_p[1], m_p[0]};
    logic [2:0]  ei = ref_irq();
    n_chk++;
    if (pending_o !== ep || irq_o !== ei) begin
      n_bad++;
      $display("FAIL %s: pending=%h irq=%b expected pending=%h irq=%b",
               tag, pending_o, irq_o, ep, ei);
    end
  endtask

  // one clock: inputs already driven at negedge
  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    evt_set_valid = 0; evt_clr_valid = 0; sw_wr_en = 0; mask_wr_en = 0;
    compare(tag);
  endtask

  task automatic do_set(string tag, logic [6:0] c);
    evt_set_valid = 1; evt_set_num = c; tick(tag);
  endtask
  task automatic do_clr(string tag, logic [6:0] c);
    evt_clr_valid = 1; evt_clr_num = c; tick(tag);
  endtask
  task automatic do_sw(string tag, logic [1:0] b, logic [31:0] d);
    sw_wr_en = 1; sw_wr_bank = b; sw_wr_data = d; tick(tag);
  endtask
  task automatic do_mask(string tag, logic [1:0] l, logic [1:0] b, logic [31:0] d);
    mask_wr_en = 1; mask_wr_level = l; mask_wr_bank = b; mask_wr_data = d; tick(tag);
  endtask

  task automatic t_reset();
    for (int b = 0; b < 3; b++) begin
      m_p[b] = 0;
      for (int l = 0; l < 3; l++) m_mask[l][b] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare("R9 reset state");
  endtask

  task automatic t_capture();
    do_set("R1 bank0 bit5", 7'h05);
    do_set("R1 R3 bank1 bit31 raises flag30", 7'h3F);
    do_set("R1 R3 bank2 bit1 raises flag31", 7'h41);
    do_set("R2 bank field 3 ignored", 7'h63);
    do_clr("R2 clear with bank field 3 ignored", 7'h7F);
  endtask

  task automatic t_root_w1c();
    do_set("R1 bank0 bit0", 7'h00);
    do_sw("R4 root write all ones", 2'd0, 32'hFFFF_FFFF);
    do_clr("R10 clear of flag31 ignored", 7'h1F);
  endtask

  task automatic t_bank1();
    do_sw("R6 software write to bank1 ignored", 2'd1, 32'hFFFF_FFFF);
    do_clr("R6 R3 event clear empties bank1", 7'h3F);
    do_set("R10 set of flag30 ignored", 7'h1E);
  endtask

  task automatic t_bank2();
    do_set("R1 bank2 bit2", 7'h42);
    do_sw("R5 partial clear keeps flag31", 2'd2, 32'h0000_0002);
    do_sw("R5 last clear drops flag31", 2'd2, 32'h0000_0004);
  endtask

  task automatic t_collide();
    evt_set_valid = 1; evt_set_num = 7'h45;
    evt_clr_valid = 1; evt_clr_num = 7'h45;
    tick("R7 set beats event clear");
    evt_set_valid = 1; evt_set_num = 7'h46;
    sw_wr_en = 1; sw_wr_bank = 2'd2; sw_wr_data = 32'h0000_0040;
    tick("R7 set beats software clear");
    evt_set_valid = 1; evt_set_num = 7'h2A;
    evt_clr_valid = 1; evt_clr_num = 7'h2A;
    tick("R7 set beats clear in bank1");
  endtask

  task automatic t_masks();
    do_mask("R8 level0 bank0 mask", 2'd0, 2'd0, 32'h0000_0008);
    do_set("R8 level0 raised", 7'h03);
    do_mask("R8 level2 bank2 mask", 2'd2, 2'd2, 32'h0001_0000);
    do_set("R8 level2 raised", 7'h50);
    do_mask("R8 level3 write ignored", 2'd3, 2'd0, 32'hFFFF_FFFF);
    do_mask("R8 bank3 write ignored", 2'd1, 2'd3, 32'hFFFF_FFFF);
    do_mask("R8 level1 on flag30", 2'd1, 2'd0, 32'h4000_0000);
    do_clr("R8 R6 bank1 empty drops level1", 7'h2A);
    do_sw("R8 root clear drops level0", 2'd0, 32'h0000_0008);
    do_mask("R8 mask cleared drops level2", 2'd2, 2'd2, 32'h0);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_root_w1c();
    t_bank1();
    t_bank2();
    t_collide();
    t_masks();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule